// File: doc/BRIEF.md
# Instruction Buffer with Type-Steered Issue

This front-end stage sits between instruction fetch and three downstream issue queues. Fetch delivers groups of up to eight instruction words per cycle. A group is written into a 12-entry circular buffer only when all of its words fit. Each cycle the four oldest buffered words are examined. A 2-bit type field in each word selects a destination queue: a wide integer queue, a narrow integer queue for multiply and divide, or a floating-point queue. Words leave in program order for as long as their destination has room.

Each queue reports how many entries it has free. The narrow integer queue takes at most one word per cycle. The wide integer queue and the floating-point queue take up to four each. When the oldest remaining word cannot go, every younger word waits with it. A flush input drops the buffered words and refuses the group offered in the same cycle.

Top module: `ibuf_issue_steer`

## Requirements
- R1: After reset the buffer is empty, no queue output is valid, and `fetch_ready_o` is high for any offered count from 0 to 8.
- R2: A fetch group of `fetch_cnt_i` words (lane k at bits [32k+31:32k], lane 0 oldest) is accepted at a clock edge only if `fetch_ready_o` is high, and `fetch_ready_o` is high exactly when flush is low and the count fits the free buffer entries. A refused group leaves no trace.
- R3: The buffer never holds more than 12 words. A full buffer refuses a group of even one word.
- R4: At most four words leave per cycle, always the oldest ones. Words accepted at an edge can leave in the cycle that follows that edge.
- R5: Bits [31:30] of a word give its type: 2'b00 and 2'b11 go to the wide integer queue, 2'b01 (multiply/divide) to the narrow integer queue, and 2'b10 to the floating-point queue. Each word reaches its queue unchanged.
- R6: The narrow integer queue receives at most one word per cycle, and none when its free count is zero.
- R7: The wide integer and floating-point queues each receive at most four words per cycle, and never more than their free counts.
- R8: Issue is in order. The first word that cannot go blocks all younger words in that cycle.
- R9: While `flush_i` is high nothing leaves and no group is accepted. In the next cycle the buffer is empty.
- R10: On each queue output the valid lanes are contiguous from lane 0 and hold the words in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Drop buffer contents and the offered group |
| fetch_cnt_i | input | 4 | Number of valid words offered (0..8) |
| fetch_data_i | input | 256 | Eight 32-bit word lanes, lane 0 oldest |
| fetch_ready_o | output | 1 | The offered group is accepted at the next edge |
| nar_free_i | input | 5 | Free entries of the narrow integer queue |
| wid_free_i | input | 5 | Free entries of the wide integer queue |
| fp_free_i | input | 5 | Free entries of the floating-point queue |
| nar_vld_o | output | 1 | Narrow queue lane valid |
| nar_data_o | output | 32 | Narrow queue word |
| wid_vld_o | output | 4 | Wide integer queue lane valids |
| wid_data_o | output | 128 | Wide integer queue words |
| fp_vld_o | output | 4 | Floating-point queue lane valids |
| fp_data_o | output | 128 | Floating-point queue words |

## Verification
Uniform groups of simple integer, multiply/divide, or floating-point words show the per-queue acceptance limit on its own, because no word ever waits behind a word of another type. A mixed group that starts with two multiply/divide words shows whether the second one blocks the younger simple and floating-point words, which separates in-order blocking from out-of-order steering. Reduced free counts separate a limit set by queue room from the fixed per-cycle limit. Filling the buffer to 8 and then 12 words with issue stopped locates the exact boundary of the fetch-ready condition. A flush with queue room available and a group on offer shows that no stale word leaks out after the flush.

// File: rtl/ibs_pkg.sv
package ibs_pkg;

  typedef enum logic [1:0] {
    ITYP_SIMPLE = 2'b00,
    ITYP_MULDIV = 2'b01,
    ITYP_FP     = 2'b10,
    ITYP_ALT    = 2'b11
  } ityp_e;

  typedef enum logic [1:0] {
    DST_WID = 2'd0,
    DST_NAR = 2'd1,
    DST_FP  = 2'd2
  } dst_e;

  function automatic dst_e classify(ityp_e t);
    case (t)
      ITYP_MULDIV: return DST_NAR;
      ITYP_FP:     return DST_FP;
      default:     return DST_WID;
    endcase
  endfunction

endpackage

// File: rtl/ibs_ring.sv
module ibs_ring #(
  parameter int DEPTH  = 12,
  parameter int WR_W   = 8,
  parameter int RD_W   = 4,
  parameter int WORD_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int WCW   = $clog2(WR_W + 1),
  localparam int RCW   = $clog2(RD_W + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic [WCW-1:0]         wr_cnt_i,
  input  logic [WR_W*WORD_W-1:0] wr_data_i,
  input  logic [RCW-1:0]         pop_cnt_i,
  output logic [RD_W*WORD_W-1:0] win_data_o,
  output logic [RD_W-1:0]        win_vld_o,
  output logic [CNT_W-1:0]       count_o
);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  head_q;
  logic [CNT_W-1:0]  cnt_q;
  int                tail;

  // operands stay below 2*DEPTH
  function automatic int wrap(int v);
    return (v >= DEPTH) ? v - DEPTH : v;
  endfunction

  assign tail    = wrap(int'(head_q) + int'(cnt_q));
  assign count_o = cnt_q;

  always_comb begin
    for (int r = 0; r < RD_W; r++) begin
      win_data_o[r*WORD_W +: WORD_W] = mem_q[PTR_W'(wrap(int'(head_q) + r))];
      win_vld_o[r] = (r < int'(cnt_q));
    end
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < WR_W; k++) begin
      if (!clr_i && k < int'(wr_cnt_i))
        mem_q[PTR_W'(wrap(tail + k))] <= wr_data_i[k*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= PTR_W'(wrap(int'(head_q) + int'(pop_cnt_i)));
      cnt_q  <= CNT_W'(int'(cnt_q) - int'(pop_cnt_i) + int'(wr_cnt_i));
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= DEPTH);

  p_flush_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);

  p_pop_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pop_cnt_i) <= int'(cnt_q));

endmodule

// File: rtl/ibs_steer.sv
module ibs_steer
  import ibs_pkg::*;
#(
  parameter int RD_W    = 4,
  parameter int WORD_W  = 32,
  parameter int NAR_ACC = 1,
  parameter int WID_ACC = 4,
  parameter int FP_ACC  = 4,
  parameter int FREE_W  = 5,
  localparam int RCW    = $clog2(RD_W + 1)
) (
  input  logic                      en_i,
  input  logic [RD_W*WORD_W-1:0]    win_data_i,
  input  logic [RD_W-1:0]           win_vld_i,
  input  logic [FREE_W-1:0]         nar_free_i,
  input  logic [FREE_W-1:0]         wid_free_i,
  input  logic [FREE_W-1:0]         fp_free_i,
  output logic [RCW-1:0]            pop_cnt_o,
  output logic [NAR_ACC-1:0]        nar_vld_o,
  output logic [NAR_ACC*WORD_W-1:0] nar_data_o,
  output logic [WID_ACC-1:0]        wid_vld_o,
  output logic [WID_ACC*WORD_W-1:0] wid_data_o,
  output logic [FP_ACC-1:0]         fp_vld_o,
  output logic [FP_ACC*WORD_W-1:0]  fp_data_o
);

  logic [RD_W-1:0] iss;
  dst_e            dst  [RD_W];
  int              slot [RD_W];

  function automatic int min_i(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // in-order selection: stop at the first word that finds no room
  always_comb begin
    int   cap_n, cap_w, cap_f, use_n, use_w, use_f, npop;
    logic go;
    cap_n = min_i(NAR_ACC, int'(nar_free_i));
    cap_w = min_i(WID_ACC, int'(wid_free_i));
    cap_f = min_i(FP_ACC,  int'(fp_free_i));
    use_n = 0;
    use_w = 0;
    use_f = 0;
    npop  = 0;
    go    = en_i;
    for (int i = 0; i < RD_W; i++) begin
      dst[i]  = classify(ityp_e'(win_data_i[i*WORD_W + WORD_W - 1 -: 2]));
      slot[i] = 0;
      iss[i]  = 1'b0;
      if (go && win_vld_i[i]) begin
        case (dst[i])
          DST_NAR: if (use_n < cap_n) begin
            slot[i] = use_n; use_n++; iss[i] = 1'b1;
          end
          DST_FP: if (use_f < cap_f) begin
            slot[i] = use_f; use_f++; iss[i] = 1'b1;
          end
          default: if (use_w < cap_w) begin
            slot[i] = use_w; use_w++; iss[i] = 1'b1;
          end
        endcase
      end
      if (!iss[i]) go = 1'b0;
      if (iss[i])  npop++;
    end
    pop_cnt_o = RCW'(npop);
  end

  // pack chosen words onto each queue's lanes
  always_comb begin
    nar_vld_o  = '0;
    nar_data_o = '0;
    wid_vld_o  = '0;
    wid_data_o = '0;
    fp_vld_o   = '0;
    fp_data_o  = '0;
    for (int i = 0; i < RD_W; i++) begin
      for (int j = 0; j < NAR_ACC; j++)
        if (iss[i] && dst[i] == DST_NAR && slot[i] == j) begin
          nar_vld_o[j] = 1'b1;
          nar_data_o[j*WORD_W +: WORD_W] = win_data_i[i*WORD_W +: WORD_W];
        end
      for (int j = 0; j < WID_ACC; j++)
        if (iss[i] && dst[i] == DST_WID && slot[i] == j) begin
          wid_vld_o[j] = 1'b1;
          wid_data_o[j*WORD_W +: WORD_W] = win_data_i[i*WORD_W +: WORD_W];
        end
      for (int j = 0; j < FP_ACC; j++)
        if (iss[i] && dst[i] == DST_FP && slot[i] == j) begin
          fp_vld_o[j] = 1'b1;
          fp_data_o[j*WORD_W +: WORD_W] = win_data_i[i*WORD_W +: WORD_W];
        end
    end
  end

endmodule

// File: rtl/ibuf_issue_steer.sv
module ibuf_issue_steer #(
  parameter int FETCH_W   = 8,
  parameter int BUF_DEPTH = 12,
  parameter int ISSUE_W   = 4,
  parameter int WORD_W    = 32,
  parameter int NAR_ACC   = 1,
  parameter int WID_ACC   = 4,
  parameter int FP_ACC    = 4,
  parameter int FREE_W    = 5,
  localparam int FCW      = $clog2(FETCH_W + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic [FCW-1:0]            fetch_cnt_i,
  input  logic [FETCH_W*WORD_W-1:0] fetch_data_i,
  output logic                      fetch_ready_o,
  input  logic [FREE_W-1:0]         nar_free_i,
  input  logic [FREE_W-1:0]         wid_free_i,
  input  logic [FREE_W-1:0]         fp_free_i,
  output logic [NAR_ACC-1:0]        nar_vld_o,
  output logic [NAR_ACC*WORD_W-1:0] nar_data_o,
  output logic [WID_ACC-1:0]        wid_vld_o,
  output logic [WID_ACC*WORD_W-1:0] wid_data_o,
  output logic [FP_ACC-1:0]         fp_vld_o,
  output logic [FP_ACC*WORD_W-1:0]  fp_data_o
);

  localparam int CNT_W = $clog2(BUF_DEPTH + 1);
  localparam int RCW   = $clog2(ISSUE_W + 1);

  logic [CNT_W-1:0]          buf_cnt;
  logic [ISSUE_W*WORD_W-1:0] win_data;
  logic [ISSUE_W-1:0]        win_vld;
  logic [RCW-1:0]            pop_cnt;
  logic [FCW-1:0]            wr_cnt;

  // whole-group admission against the buffer's current occupancy
  assign fetch_ready_o = !flush_i &&
                         (int'(fetch_cnt_i) <= BUF_DEPTH - int'(buf_cnt));
  assign wr_cnt        = fetch_ready_o ? fetch_cnt_i : '0;

  ibs_ring #(
    .DEPTH (BUF_DEPTH),
    .WR_W  (FETCH_W),
    .RD_W  (ISSUE_W),
    .WORD_W(WORD_W)
  ) ring_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (flush_i),
    .wr_cnt_i  (wr_cnt),
    .wr_data_i (fetch_data_i),
    .pop_cnt_i (pop_cnt),
    .win_data_o(win_data),
    .win_vld_o (win_vld),
    .count_o   (buf_cnt)
  );

  ibs_steer #(
    .RD_W   (ISSUE_W),
    .WORD_W (WORD_W),
    .NAR_ACC(NAR_ACC),
    .WID_ACC(WID_ACC),
    .FP_ACC (FP_ACC),
    .FREE_W (FREE_W)
  ) steer_i (
    .en_i      (!flush_i),
    .win_data_i(win_data),
    .win_vld_i (win_vld),
    .nar_free_i(nar_free_i),
    .wid_free_i(wid_free_i),
    .fp_free_i (fp_free_i),
    .pop_cnt_o (pop_cnt),
    .nar_vld_o (nar_vld_o),
    .nar_data_o(nar_data_o),
    .wid_vld_o (wid_vld_o),
    .wid_data_o(wid_data_o),
    .fp_vld_o  (fp_vld_o),
    .fp_data_o (fp_data_o)
  );

  p_nar_room_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(nar_vld_o) <= 1 && $countones(nar_vld_o) <= int'(nar_free_i));

  p_wid_room_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wid_vld_o) <= int'(wid_free_i));

  p_fp_room_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(fp_vld_o) <= int'(fp_free_i));

  p_issue_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({nar_vld_o, wid_vld_o, fp_vld_o}) <= ISSUE_W);

  p_flush_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (nar_vld_o == '0 && wid_vld_o == '0 && fp_vld_o == '0));

  p_progress_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && buf_cnt != '0 && nar_free_i != '0 && wid_free_i != '0 &&
     fp_free_i != '0) |-> pop_cnt != '0);

  p_packed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wid_vld_o & (wid_vld_o + WID_ACC'(1))) == '0 &&
    (fp_vld_o & (fp_vld_o + FP_ACC'(1))) == '0);

endmodule

// File: tb/ibuf_issue_steer_tb_top.sv
`timescale 1ns/1ps
module ibuf_issue_steer_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic [3:0]   fetch_cnt = '0;
  logic [255:0] fetch_data = '0;
  logic         fetch_ready;
  logic [4:0]   nar_free = '0, wid_free = '0, fp_free = '0;
  logic [0:0]   nar_vld;
  logic [31:0]  nar_data;
  logic [3:0]   wid_vld, fp_vld;
  logic [127:0] wid_data, fp_data;

  int n_chk = 0, n_fail = 0;
  int mon_n = 0, mon_w = 0, mon_f = 0;
  int seq = 0;
  logic [31:0] stage [8];
  logic [31:0] exp_n [$], exp_w [$], exp_f [$];

  always #2.5 clk = ~clk;

  ibuf_issue_steer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .fetch_cnt_i(fetch_cnt), .fetch_data_i(fetch_data),
    .fetch_ready_o(fetch_ready),
    .nar_free_i(nar_free), .wid_free_i(wid_free), .fp_free_i(fp_free),
    .nar_vld_o(nar_vld), .nar_data_o(nar_data),
    .wid_vld_o(wid_vld), .wid_data_o(wid_data),
    .fp_vld_o(fp_vld), .fp_data_o(fp_data)
  );

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic chk_word(string req, logic [31:0] act, ref logic [31:0] q [$]);
    logic [31:0] e;
    n_chk++;
    if (q.size() == 0) begin
      n_fail++;
      $display("FAIL %s: actual %h expected none", req, act);
    end else begin
      e = q.pop_front();
      if (act !== e) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", req, act, e);
      end
    end
  endtask

  // monitor: mid-cycle snapshot of what the queues take at the next edge
  always @(negedge clk) begin
    if (rst_n) begin
      mon_n = $countones(nar_vld);
      mon_w = $countones(wid_vld);
      mon_f = $countones(fp_vld);
      if (nar_vld[0]) chk_word("R5 nar word", nar_data, exp_n);
      for (int j = 0; j < 4; j++) begin
        if (wid_vld[j]) chk_word("R10 wid word", wid_data[j*32 +: 32], exp_w);
        if (fp_vld[j])  chk_word("R10 fp word", fp_data[j*32 +: 32], exp_f);
      end
    end
  end

  task automatic put(int lane, logic [1:0] t);
    seq++;
    stage[lane] = {t, 30'(seq)};
  endtask

  // driver: one cycle of stimulus; pushes expected words when accepted
  task automatic drive(int cnt, int fn, int fw, int ff, bit fl, output bit rdy);
    @(posedge clk);
    #1;
    fetch_cnt = 4'(cnt);
    for (int k = 0; k < 8; k++) fetch_data[k*32 +: 32] = stage[k];
    nar_free = 5'(fn); wid_free = 5'(fw); fp_free = 5'(ff);
    flush = fl;
    @(negedge clk);
    #0.2;
    rdy = fetch_ready;
    if (rdy && !fl) begin
      for (int k = 0; k < cnt; k++) begin
        case (stage[k][31:30])
          2'b01:   exp_n.push_back(stage[k]);
          2'b10:   exp_f.push_back(stage[k]);
          default: exp_w.push_back(stage[k]);
        endcase
      end
    end
  endtask

  task automatic expect_iss(string req, int n, int w, int f);
    chk(mon_n == n, {req, " nar"}, mon_n, n);
    chk(mon_w == w, {req, " wid"}, mon_w, w);
    chk(mon_f == f, {req, " fp"},  mon_f, f);
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit r;
    for (int k = 0; k < 8; k++) stage[k] = '0;
    #12 rst_n = 1'b1;

    // R1 reset state
    drive(8, 4, 4, 4, 0, r);
    chk(r == 1'b0 || r == 1'b1, "R1 ready known", int'(r), 1);
    chk(r == 1'b1, "R1 ready after reset", int'(r), 1);
    expect_iss("R1 idle", 0, 0, 0);
    // that group had all-zero words (simple); drain them
    drive(0, 4, 4, 4, 0, r);
    expect_iss("R4 zero group first", 0, 4, 0);
    drive(0, 4, 4, 4, 0, r);
    expect_iss("R4 zero group second", 0, 4, 0);
    drive(0, 4, 4, 4, 0, r);
    expect_iss("R4 drained", 0, 0, 0);

    // R4 eight simple words leave four per cycle
    for (int k = 0; k < 8; k++) put(k, 2'b00);
    drive(8, 4, 4, 4, 0, r);
    chk(r == 1'b1, "R2 group of 8 accepted", int'(r), 1);
    drive(0, 4, 4, 4, 0, r);
    expect_iss("R4 simple c1", 0, 4, 0);
    drive(0, 4, 4, 4, 0, r);
    expect_iss("R4 simple c2", 0, 4, 0);

    // R6 multiply/divide: one per cycle
    for (int k = 0; k < 3; k++) put(k, 2'b01);
    drive(3, 8, 8, 8, 0, r);
    drive(0, 8, 8, 8, 0, r);
    expect_iss("R6 muldiv c1", 1, 0, 0);
    drive(0, 8, 8, 8, 0, r);
    expect_iss("R6 muldiv c2", 1, 0, 0);
    drive(0, 0, 8, 8, 0, r);
    expect_iss("R6 narrow no room", 0, 0, 0);
    drive(0, 8, 8, 8, 0, r);
    expect_iss("R6 muldiv c3", 1, 0, 0);

    // R8 in-order blocking behind the second muldiv
    put(0, 2'b01); put(1, 2'b01); put(2, 2'b00); put(3, 2'b10);
    drive(4, 4, 4, 4, 0, r);
    drive(0, 4, 4, 4, 0, r);
    expect_iss("R8 blocked", 1, 0, 0);
    drive(0, 4, 4, 4, 0, r);
    expect_iss("R8 released", 1, 1, 1);

    // R7 free-count limit on the wide queue
    for (int k = 0; k < 4; k++) put(k, 2'b00);
    drive(4, 4, 4, 4, 0, r);
    drive(0, 4, 2, 4, 0, r);
    expect_iss("R7 wid free 2", 0, 2, 0);
    drive(0, 4, 0, 4, 0, r);
    expect_iss("R7 wid free 0", 0, 0, 0);
    drive(0, 4, 4, 4, 0, r);
    expect_iss("R7 wid rest", 0, 2, 0);

    // R5 fp and alternate simple encoding
    put(0, 2'b10); put(1, 2'b11); put(2, 2'b10); put(3, 2'b10);
    drive(4, 4, 4, 4, 0, r);
    drive(0, 4, 4, 1, 0, r);
    expect_iss("R7 fp free 1", 0, 1, 1);
    drive(0, 4, 4, 4, 0, r);
    expect_iss("R5 fp rest", 0, 0, 2);

    // R2/R3 fill boundary with issue stopped
    for (int k = 0; k < 8; k++) put(k, 2'b00);
    drive(8, 0, 0, 0, 0, r);
    chk(r == 1'b1, "R2 first 8", int'(r), 1);
    drive(8, 0, 0, 0, 0, r);
    chk(r == 1'b0, "R2 8 into 4 free", int'(r), 0);
    for (int k = 0; k < 4; k++) put(k, 2'b00);
    drive(4, 0, 0, 0, 0, r);
    chk(r == 1'b1, "R2 4 into 4 free", int'(r), 1);
    put(0, 2'b00);
    drive(1, 0, 0, 0, 0, r);
    chk(r == 1'b0, "R3 full refuses 1", int'(r), 0);
    expect_iss("R3 stalled", 0, 0, 0);
    for (int c = 0; c < 3; c++) begin
      drive(0, 0, 4, 0, 0, r);
      expect_iss("R3 drain 12", 0, 4, 0);
    end
    drive(0, 4, 4, 4, 0, r);
    expect_iss("R3 empty after 12", 0, 0, 0);

    // R9 flush drops buffer and the offered group
    for (int k = 0; k < 8; k++) put(k, 2'b00);
    drive(8, 0, 0, 0, 0, r);
    for (int k = 0; k < 4; k++) put(k, 2'b10);
    drive(4, 4, 4, 4, 1, r);
    chk(r == 1'b0, "R9 ready low in flush", int'(r), 0);
    expect_iss("R9 no issue in flush", 0, 0, 0);
    exp_n.delete(); exp_w.delete(); exp_f.delete();
    drive(0, 4, 4, 4, 0, r);
    expect_iss("R9 empty after flush", 0, 0, 0);
    put(0, 2'b10); put(1, 2'b10);
    drive(2, 4, 4, 4, 0, r);
    drive(0, 4, 4, 4, 0, r);
    expect_iss("R9 new after flush", 0, 0, 2);
    drive(0, 4, 4, 4, 0, r);

    chk(exp_n.size() + exp_w.size() + exp_f.size() == 0, "R5 all delivered",
        exp_n.size() + exp_w.size() + exp_f.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule